// File: doc/BRIEF.md
# System Exception Control and Status Word

This block is the software-facing control and status word for the system exceptions of an interrupt controller. A write to the control word raises or withdraws the pending state of three system exceptions: the non-maskable interrupt, the deferred service call and the periodic tick. The block does this by issuing single-cycle set and clear strobes to the pending logic, which sits outside this block. A read returns a packed summary of the exception state. The summary holds the vector that is currently active and the highest pending vector. It also has a flag for any pending external interrupt, a flag for other active external interrupts, and the pending bits of the three system exceptions.

A second word, the software trigger, takes an external interrupt number in its low nine bits. It raises a trigger strobe carrying that number, but only when the number is below the configured external interrupt count. The block does no priority arbitration. The active and pending vector numbers come in from the arbiter, and external interrupts are numbered from 16 in every vector field. Reads have one cycle of latency. Writes act in the cycle they are presented.

Top module: `sysexc_ctrl_word`

## Requirements
- R1: A write to offset 0xD04 with bit 31 set pulses `nmi_set_o` in that cycle.
- R2: In a write to 0xD04, bit 28 pulses `psv_set_o` and bit 27 pulses `psv_clr_o`. When both bits are 1, only `psv_set_o` pulses.
- R3: In a write to 0xD04, bit 26 pulses `tick_set_o` and bit 25 pulses `tick_clr_o`. When both bits are 1, only `tick_set_o` pulses.
- R4: All strobes are combinational from the write cycle and last exactly that cycle. No strobe is high in a cycle without `bus_wr`.
- R5: A read of 0xD04 returns the active vector in bits 8:0 when `act_vld` is 1, and 0 in those bits when nothing is active.
- R6: Bits 20:12 of the read word carry `pend_vec` when `pend_vld` is 1, and read 0 otherwise.
- R7: Bit 22 of the read word is 1 exactly when some bit of `ext_pend` is 1.
- R8: Bit 11 of the read word is 1 exactly when some external interrupt i has `ext_act[i]` set and is not the current active vector. The current active vector is 16+i with `act_vld` set.
- R9: Bits 26, 28 and 31 of the read word reflect `tick_pend`, `psv_pend` and `nmi_pend`. All other read bits are 0.
- R10: A write to 0xF00 takes bits 8:0 as an interrupt number. If that number is below NUM_EXT, `swi_fire_o` pulses and `swi_id_o` holds the number. Otherwise nothing happens. Bits 31:9 are ignored.
- R11: Writes to any other offset produce no strobe. Reads of any offset other than 0xD04 return 0, and this includes 0xF00.
- R12: `bus_rvalid` is high in the cycle after each `bus_rd` and low otherwise. `bus_rdata` is the word sampled at the `bus_rd` cycle. Both outputs are 0 in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Write request |
| bus_rd | input | 1 | Read request |
| bus_addr | input | 12 | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after `bus_rd` |
| bus_rvalid | output | 1 | Read data valid |
| act_vld | input | 1 | An exception is active |
| act_vec | input | 9 | Active vector number |
| pend_vld | input | 1 | Some exception is pending |
| pend_vec | input | 9 | Highest pending vector number |
| ext_pend | input | NUM_EXT | External interrupt pending bits |
| ext_act | input | NUM_EXT | External interrupt active bits |
| nmi_pend | input | 1 | NMI pending state |
| psv_pend | input | 1 | Deferred service call pending state |
| tick_pend | input | 1 | Tick pending state |
| nmi_set_o | output | 1 | Set NMI pending |
| psv_set_o | output | 1 | Set deferred call pending |
| psv_clr_o | output | 1 | Clear deferred call pending |
| tick_set_o | output | 1 | Set tick pending |
| tick_clr_o | output | 1 | Clear tick pending |
| swi_fire_o | output | 1 | Software trigger strobe |
| swi_id_o | output | 9 | Triggered external interrupt number |

## Verification
The bench writes set and clear together for both paired exceptions. A design that let clear win, or that let the two bits cancel, would pulse the clear strobe or no strobe at all. It places the only active external interrupt on the current vector, and then beside it. A design that forgot the exclusion, or compared against the wrong vector base, would flip bit 11. It triggers interrupt numbers 63, 64 and 0x1FF, and puts junk in the upper data bits. An off-by-one range check would fire on 64, and a wide decode would drop the trigger entirely. Reads of the trigger word and of unlisted offsets must return 0, and a write of all ones to a neighbouring offset must stay silent.

// File: rtl/sysexc_pkg.sv
package sysexc_pkg;
  localparam int unsigned ADDR_W   = 12;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned VEC_W    = 9;
  localparam int unsigned EXT_BASE = 16;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 12'hD04;
  localparam logic [ADDR_W-1:0] OFS_TRIG = 12'hF00;

  // Bit positions shared by the write decode and the read packing
  localparam int unsigned B_NMI_SET  = 31;
  localparam int unsigned B_PSV_SET  = 28;
  localparam int unsigned B_PSV_CLR  = 27;
  localparam int unsigned B_TICK_SET = 26;
  localparam int unsigned B_TICK_CLR = 25;
  localparam int unsigned B_ANY_PEND = 22;
  localparam int unsigned B_PEND_LSB = 12;
  localparam int unsigned B_OTHER    = 11;

  // Set wins over clear in the same word
  function automatic logic clr_gate(input logic set_b, input logic clr_b);
    return clr_b & ~set_b;
  endfunction

  function automatic logic [DATA_W-1:0] pack_word(
      input logic [VEC_W-1:0] act_f, input logic other_act,
      input logic [VEC_W-1:0] pend_f, input logic any_pend,
      input logic tick_p, input logic psv_p, input logic nmi_p);
    logic [DATA_W-1:0] w;
    w = '0;
    w[VEC_W-1:0]                   = act_f;
    w[B_OTHER]                     = other_act;
    w[B_PEND_LSB +: VEC_W]         = pend_f;
    w[B_ANY_PEND]                  = any_pend;
    w[B_TICK_SET]                  = tick_p;
    w[B_PSV_SET]                   = psv_p;
    w[B_NMI_SET]                   = nmi_p;
    return w;
  endfunction
endpackage

// File: rtl/sysexc_wr_decode.sv
module sysexc_wr_decode
  import sysexc_pkg::*;
#(
  parameter int unsigned NUM_EXT = 64
) (
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              nmi_set,
  output logic              psv_set,
  output logic              psv_clr,
  output logic              tick_set,
  output logic              tick_clr,
  output logic              swi_fire,
  output logic [VEC_W-1:0]  swi_id
);
  localparam logic [VEC_W:0] ID_LIMIT = (VEC_W+1)'(NUM_EXT);

  logic hit_ctrl, hit_trig, id_in_range;
  logic unused_bits;

  assign hit_ctrl    = wr && (addr == OFS_CTRL);
  assign hit_trig    = wr && (addr == OFS_TRIG);
  assign swi_id      = wdata[VEC_W-1:0];
  assign id_in_range = {1'b0, swi_id} < ID_LIMIT;

  assign nmi_set  = hit_ctrl & wdata[B_NMI_SET];
  assign psv_set  = hit_ctrl & wdata[B_PSV_SET];
  assign psv_clr  = hit_ctrl & clr_gate(wdata[B_PSV_SET], wdata[B_PSV_CLR]);
  assign tick_set = hit_ctrl & wdata[B_TICK_SET];
  assign tick_clr = hit_ctrl & clr_gate(wdata[B_TICK_SET], wdata[B_TICK_CLR]);
  assign swi_fire = hit_trig & id_in_range;

  assign unused_bits = ^{wdata[30:29], wdata[24:VEC_W]};
endmodule

// File: rtl/sysexc_status_pack.sv
module sysexc_status_pack
  import sysexc_pkg::*;
#(
  parameter int unsigned NUM_EXT = 64
) (
  input  logic               act_vld,
  input  logic [VEC_W-1:0]   act_vec,
  input  logic               pend_vld,
  input  logic [VEC_W-1:0]   pend_vec,
  input  logic [NUM_EXT-1:0] ext_pend,
  input  logic [NUM_EXT-1:0] ext_act,
  input  logic               nmi_pend,
  input  logic               psv_pend,
  input  logic               tick_pend,
  output logic [DATA_W-1:0]  word
);
  logic [NUM_EXT-1:0] other_hit;

  for (genvar i = 0; i < NUM_EXT; i++) begin : g_other
    localparam logic [VEC_W-1:0] MY_VEC = VEC_W'(EXT_BASE + i);
    assign other_hit[i] = ext_act[i] & ~(act_vld && (act_vec == MY_VEC));
  end

  assign word = pack_word(act_vld ? act_vec : '0, |other_hit,
                          pend_vld ? pend_vec : '0, |ext_pend,
                          tick_pend, psv_pend, nmi_pend);
endmodule

// File: rtl/sysexc_ctrl_word.sv
module sysexc_ctrl_word
  import sysexc_pkg::*;
#(
  parameter int unsigned NUM_EXT = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [11:0]        bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               bus_rvalid,
  input  logic               act_vld,
  input  logic [8:0]         act_vec,
  input  logic               pend_vld,
  input  logic [8:0]         pend_vec,
  input  logic [NUM_EXT-1:0] ext_pend,
  input  logic [NUM_EXT-1:0] ext_act,
  input  logic               nmi_pend,
  input  logic               psv_pend,
  input  logic               tick_pend,
  output logic               nmi_set_o,
  output logic               psv_set_o,
  output logic               psv_clr_o,
  output logic               tick_set_o,
  output logic               tick_clr_o,
  output logic               swi_fire_o,
  output logic [8:0]         swi_id_o
);
  logic [DATA_W-1:0] status_word;
  logic [DATA_W-1:0] rd_mux;

  sysexc_wr_decode #(.NUM_EXT(NUM_EXT)) u_dec (
    .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .nmi_set(nmi_set_o), .psv_set(psv_set_o), .psv_clr(psv_clr_o),
    .tick_set(tick_set_o), .tick_clr(tick_clr_o),
    .swi_fire(swi_fire_o), .swi_id(swi_id_o)
  );

  sysexc_status_pack #(.NUM_EXT(NUM_EXT)) u_pack (
    .act_vld(act_vld), .act_vec(act_vec),
    .pend_vld(pend_vld), .pend_vec(pend_vec),
    .ext_pend(ext_pend), .ext_act(ext_act),
    .nmi_pend(nmi_pend), .psv_pend(psv_pend), .tick_pend(tick_pend),
    .word(status_word)
  );

  assign rd_mux = (bus_addr == OFS_CTRL) ? status_word : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/sysexc_ctrl_word_chk.sv
module sysexc_ctrl_word_chk
  import sysexc_pkg::*;
#(
  parameter int unsigned NUM_EXT = 64
) (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic [11:0] bus_addr,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic        bus_rvalid,
  input logic        nmi_set_o,
  input logic        psv_set_o,
  input logic        psv_clr_o,
  input logic        tick_set_o,
  input logic        tick_clr_o,
  input logic        swi_fire_o,
  input logic [8:0]  swi_id_o
);
  logic any_ctrl_strobe;
  assign any_ctrl_strobe = nmi_set_o | psv_set_o | psv_clr_o | tick_set_o | tick_clr_o;

  assert_nmi_src_R1: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_set_o |-> (bus_wr && bus_addr == OFS_CTRL && bus_wdata[31]));

  assert_psv_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(psv_set_o && psv_clr_o));

  assert_tick_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick_set_o && tick_clr_o));

  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |-> !(any_ctrl_strobe || swi_fire_o));

  assert_swi_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    swi_fire_o |-> ({1'b0, swi_id_o} < 10'(NUM_EXT)));

  assert_other_ofs_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr != OFS_CTRL) |-> !any_ctrl_strobe);

  assert_zero_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr != OFS_CTRL) |=> (bus_rdata == '0));

  assert_rvalid_follow_R12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);

  assert_rvalid_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_rvalid);
endmodule

bind sysexc_ctrl_word sysexc_ctrl_word_chk #(.NUM_EXT(NUM_EXT)) u_chk (.*);

// File: tb/sysexc_ctrl_word_test.sv
module sysexc_ctrl_word_test;
  localparam int NEXT = 64;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, bus_wr, bus_rd;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic bus_rvalid, act_vld, pend_vld, nmi_pend, psv_pend, tick_pend;
  logic [8:0] act_vec, pend_vec, swi_id_o;
  logic [NEXT-1:0] ext_pend, ext_act;
  logic nmi_set_o, psv_set_o, psv_clr_o, tick_set_o, tick_clr_o, swi_fire_o;

  sysexc_ctrl_word #(.NUM_EXT(NEXT)) uut (.*);

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Independent model of the read word from the requirements
  function automatic logic [31:0] model_word();
    logic [31:0] w = 32'h0;
    logic other = 1'b0;
    if (act_vld) w = w | 32'(act_vec);                     // R5
    if (pend_vld) w = w | (32'(pend_vec) << 12);           // R6
    if (ext_pend != '0) w = w | 32'h0040_0000;             // R7
    for (int i = 0; i < NEXT; i++)
      if (ext_act[i] && !(act_vld && int'(act_vec) == i + 16)) other = 1'b1;
    if (other) w = w | 32'h0000_0800;                      // R8
    if (tick_pend) w = w | 32'h0400_0000;                  // R9
    if (psv_pend)  w = w | 32'h1000_0000;
    if (nmi_pend)  w = w | 32'h8000_0000;
    return w;
  endfunction

  // Driver: push expected read data, present one read cycle
  task automatic do_read(logic [11:0] a, logic [31:0] e, string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // Monitor: pop and compare as read data arrives
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) chk("R12 unexpected rvalid", 32'd1, 32'd0);
      else chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  function automatic logic [5:0] strobes();
    return {nmi_set_o, psv_set_o, psv_clr_o, tick_set_o, tick_clr_o, swi_fire_o};
  endfunction

  // exp order: {nmi_set, psv_set, psv_clr, tick_set, tick_clr, swi_fire}
  task automatic do_write(logic [11:0] a, logic [31:0] d, logic [5:0] exp, logic [8:0] id, string tag);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    #1;
    chk(tag, 32'(strobes()), 32'(exp));
    if (exp[0]) chk({tag, " id"}, 32'(swi_id_o), 32'(id));
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = 32'hFFFF_FFFF;
    #1;
    chk("R4 strobes drop after write", 32'(strobes()), 32'd0);
  endtask

  initial begin
    #(8 * 20000);
    chk("watchdog expired", 32'd1, 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b1; bus_addr = 12'hD04; bus_wdata = '0;
    act_vld = 0; act_vec = '0; pend_vld = 0; pend_vec = '0;
    ext_pend = '0; ext_act = '0; nmi_pend = 0; psv_pend = 0; tick_pend = 0;
    repeat (3) @(negedge clk);
    chk("R12 reset rvalid", 32'(bus_rvalid), 32'd0);
    chk("R12 reset rdata", bus_rdata, 32'd0);
    bus_rd = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R4 idle strobes", 32'(strobes()), 32'd0);

    do_write(12'hD04, 32'h8000_0000, 6'b100000, '0, "R1 nmi set");
    do_write(12'hD04, 32'h1800_0000, 6'b010000, '0, "R2 psv set beats clear");
    do_write(12'hD04, 32'h0800_0000, 6'b001000, '0, "R2 psv clear");
    do_write(12'hD04, 32'h0600_0000, 6'b000100, '0, "R3 tick set beats clear");
    do_write(12'hD04, 32'h0200_0000, 6'b000010, '0, "R3 tick clear");
    do_write(12'hD04, 32'h9E00_0000, 6'b110100, '0, "R1 R2 R3 all set");
    do_write(12'hD04, 32'h0A00_0000, 6'b001010, '0, "R2 R3 both clears");
    do_write(12'hD08, 32'hFFFF_FFFF, 6'b000000, '0, "R11 other offset write");
    do_write(12'hF04, 32'h0000_0005, 6'b000000, '0, "R11 near trigger offset");

    do_write(12'hF00, 32'h0000_0005, 6'b000001, 9'd5, "R10 trigger 5");
    do_write(12'hF00, 32'h0000_003F, 6'b000001, 9'd63, "R10 trigger last");
    do_write(12'hF00, 32'h0000_0040, 6'b000000, '0, "R10 trigger at count");
    do_write(12'hF00, 32'h0000_01FF, 6'b000000, '0, "R10 trigger max field");
    do_write(12'hF00, 32'hFFFF_FE07, 6'b000001, 9'd7, "R10 upper bits ignored");

    do_read(12'hD04, 32'h0, "R5 R6 idle word");
    act_vld = 1; act_vec = 9'd3;
    do_read(12'hD04, model_word(), "R5 active vector 3");
    act_vec = 9'd20; ext_act[4] = 1'b1;
    do_read(12'hD04, model_word(), "R8 only current active");
    ext_act[5] = 1'b1;
    do_read(12'hD04, model_word(), "R8 another active");
    act_vld = 0;
    ext_act = '0; ext_act[4] = 1'b1;
    do_read(12'hD04, model_word(), "R5 R8 none active field");
    ext_act = '0; act_vld = 1; act_vec = 9'd79; ext_act[NEXT-1] = 1'b1;
    do_read(12'hD04, model_word(), "R8 top interrupt current");
    pend_vld = 1; pend_vec = 9'd37;
    do_read(12'hD04, model_word(), "R6 pending vector");
    pend_vld = 0; pend_vec = 9'h1FF;
    do_read(12'hD04, model_word(), "R6 pending not valid");
    ext_pend[33] = 1'b1;
    do_read(12'hD04, model_word(), "R7 any pending");
    nmi_pend = 1; psv_pend = 1; tick_pend = 1;
    do_read(12'hD04, model_word(), "R9 system pending bits");
    nmi_pend = 0; tick_pend = 0;
    do_read(12'hD04, model_word(), "R9 psv only");
    do_read(12'hF00, 32'h0, "R11 trigger word reads 0");
    do_read(12'hD08, 32'h0, "R11 unlisted read");

    repeat (3) @(negedge clk);
    chk("R12 all reads returned", 32'(exp_q.size()), 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule